// File: doc/BRIEF.md
# Nibble-Sliced Shift-and-Add Aggregator

This block rebuilds wide multiply-accumulate results from narrow partial sums that arrive one time slot at a time. Each operand is handled in 4-bit slices. For 8-bit operands, every slice of one operand is paired with every slice of the other, so a result takes four slots. For 4-bit operands it takes a single slot. In each slot, four lanes each deliver a 5-bit digitized partial sum. The 5-bit width keeps the carry of the in-channel addition. The block shifts every lane sample by the combined significance of the slice pair for that slot and adds it into a per-lane accumulator.

When the last slot has been absorbed, the lane accumulators are added together into a single output element. A 16-entry local buffer can take part in the result. On request, the value stored at the selected entry is added to the final sum, and the finished result can be written back to that entry. This lets a long reduction be split over several operations.

Top module: `nibble_mac_gather`

## Requirements
- R1: After reset, `slot_ready` and `result_valid` are low and every buffer entry holds zero.
- R2: A `start` pulse while the block is idle begins an operation, and `slot_ready` rises on the following cycle. A `start` while an operation is in progress or its result is being presented is ignored: mode, address and flags keep their captured values.
- R3: With `wide_mode`=0, a single accepted slot completes the operation, and the four lane samples are added with no shift.
- R4: With `wide_mode`=1, four slots are accepted in the order (A0,B0), (A0,B1), (A1,B0), (A1,B1). Their samples are shifted left by 0, 4, 4 and 8 bits. Idle cycles between slots do not change the result.
- R5: The result is the sum over all four lanes, where lane k occupies `slot_data[5k+4:5k]`.
- R6: `result_valid` is high for exactly one cycle. That cycle is the one after the last slot is accepted.
- R7: A slot is accepted only when `slot_valid` and `slot_ready` are both high. `slot_ready` is low while idle and while `result_valid` is high, and slot inputs offered then have no effect on any result.
- R8: When `add_prev`=1 at start, the buffer entry at `buf_addr` is added to the lane sum. When it is 0, nothing is added.
- R9: When `store_result`=1 at start, the presented result is written into the buffer entry at `buf_addr` at the end of the valid cycle.
- R10: Results are taken modulo 2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (used only while idle) |
| wide_mode | input | 1 | 1: 8-bit operands (four slots); 0: 4-bit operands (one slot) |
| buf_addr | input | 4 | Buffer entry used by this operation |
| add_prev | input | 1 | Add the buffered value to the final sum |
| store_result | input | 1 | Write the final sum back to the buffer |
| slot_valid | input | 1 | Slot samples are present |
| slot_data | input | 20 | Four 5-bit lane samples |
| slot_ready | output | 1 | Block accepts a slot this cycle |
| result_valid | output | 1 | Final sum presented this cycle |
| result_data | output | 24 | Final sum |

## Verification
The hardest situation to reach from the ports is wraparound of the 24-bit result. A single operation can add at most about 36 thousand, so no single operation can overflow. The stimulus chains several hundred wide operations with all lane samples at their maximum, each adding the buffered value and storing the new total at the same entry, until the running sum crosses 2^24. Start pulses placed in the middle of an operation and slots offered during the valid cycle check that captured state cannot be disturbed.

// File: rtl/nibble_mac_gather.sv
module nibble_mac_gather #(
  parameter int LANES     = 4,
  parameter int NIB_W     = 4,
  parameter int SAMPLE_W  = 5,
  parameter int ACC_W     = 24,
  parameter int BUF_DEPTH = 16,
  localparam int ADDR_W   = $clog2(BUF_DEPTH),
  localparam int SH_W     = $clog2(2 * NIB_W + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      wide_mode,
  input  logic [ADDR_W-1:0]         buf_addr,
  input  logic                      add_prev,
  input  logic                      store_result,
  input  logic                      slot_valid,
  input  logic [LANES*SAMPLE_W-1:0] slot_data,
  output logic                      slot_ready,
  output logic                      result_valid,
  output logic [ACC_W-1:0]          result_data
);
  localparam logic [1:0] IDLE = 2'd0, RUN = 2'd1, DONE = 2'd2;

  logic [1:0]        phase;
  logic              wide_q, addp_q, store_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        slot_q;
  logic [ACC_W-1:0]  acc_q [LANES];
  logic [ACC_W-1:0]  buf_q [BUF_DEPTH];
  logic [ACC_W-1:0]  lane_total;
  logic [SH_W-1:0]   shamt;

  assign slot_ready   = (phase == RUN);
  assign result_valid = (phase == DONE);

  wire begin_op = start && (phase == IDLE);
  wire take     = slot_valid && slot_ready;
  wire last     = !wide_q || (slot_q == 2'd3);

  assign shamt = wide_q ? SH_W'(NIB_W * (int'(slot_q[1]) + int'(slot_q[0]))) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= IDLE;
      wide_q  <= 1'b0;
      addp_q  <= 1'b0;
      store_q <= 1'b0;
      addr_q  <= '0;
      slot_q  <= '0;
    end else begin
      case (phase)
        IDLE: if (start) begin
          phase   <= RUN;
          wide_q  <= wide_mode;
          addp_q  <= add_prev;
          store_q <= store_result;
          addr_q  <= buf_addr;
          slot_q  <= '0;
        end
        RUN: if (take) begin
          slot_q <= slot_q + 2'd1;
          if (last) phase <= DONE;
        end
        default: phase <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (!rst_n || begin_op)
        acc_q[l] <= '0;
      else if (take)
        acc_q[l] <= acc_q[l] + (ACC_W'(slot_data[l*SAMPLE_W +: SAMPLE_W]) << shamt);
    end
  end

  always_comb begin
    lane_total = '0;
    for (int l = 0; l < LANES; l++) lane_total = lane_total + acc_q[l];
  end

  assign result_data = lane_total + (addp_q ? buf_q[addr_q] : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < BUF_DEPTH; e++) buf_q[e] <= '0;
    end else if (result_valid && store_q) begin
      buf_q[addr_q] <= result_data;
    end
  end
endmodule

// File: rtl/nibble_mac_gather_chk.sv
module nibble_mac_gather_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic slot_valid,
  input logic slot_ready,
  input logic result_valid,
  input logic wide_q
);
  logic [2:0] seen;

  always_ff @(posedge clk) begin
    if (!rst_n || result_valid) seen <= '0;
    else if (slot_valid && slot_ready) seen <= seen + 3'd1;
  end

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  // R7
  ready_low_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> !slot_ready);

  // R2
  ready_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_ready) |-> $past(start));

  // R3
  narrow_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && slot_ready && !wide_q) |=> result_valid);

  // R4
  slot_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (seen == (wide_q ? 3'd4 : 3'd1)));
endmodule

bind nibble_mac_gather nibble_mac_gather_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .start(start),
  .slot_valid(slot_valid),
  .slot_ready(slot_ready),
  .result_valid(result_valid),
  .wide_q(wide_q)
);

// File: tb/nibble_mac_gather_test.sv
module nibble_mac_gather_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, wide_mode = 1'b0, add_prev = 1'b0, store_result = 1'b0;
  logic [3:0]  buf_addr = '0;
  logic        slot_valid = 1'b0;
  logic [19:0] slot_data = '0;
  logic        slot_ready, result_valid;
  logic [23:0] result_data;

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R3";

  always #2 clk = ~clk;

  nibble_mac_gather uut (
    .clk(clk), .rst_n(rst_n), .start(start), .wide_mode(wide_mode),
    .buf_addr(buf_addr), .add_prev(add_prev), .store_result(store_result),
    .slot_valid(slot_valid), .slot_data(slot_data),
    .slot_ready(slot_ready), .result_valid(result_valid), .result_data(result_data)
  );

  // behavioural reference model
  int      m_phase = 0;
  int      m_shifts[$];
  longint  m_sum = 0;
  longint  m_buf[16];
  bit      m_addp = 0, m_st = 0;
  int      m_addr = 0;

  function automatic longint m_result();
    return (m_sum + (m_addp ? m_buf[m_addr] : 0)) & 64'hFFFFFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0;
      m_shifts.delete();
      for (int e = 0; e < 16; e++) m_buf[e] = 0;
    end else begin
      case (m_phase)
        0: if (start) begin
          m_shifts.delete();
          if (wide_mode) begin
            m_shifts.push_back(0); m_shifts.push_back(4);
            m_shifts.push_back(4); m_shifts.push_back(8);
          end else m_shifts.push_back(0);
          m_sum = 0; m_addp = add_prev; m_st = store_result; m_addr = int'(buf_addr);
          m_phase = 1;
        end
        1: if (slot_valid) begin
          int sh;
          sh = m_shifts.pop_front();
          for (int l = 0; l < 4; l++) m_sum += longint'(slot_data[l*5 +: 5]) << sh;
          if (m_shifts.size() == 0) m_phase = 2;
        end
        default: begin
          if (m_st) m_buf[m_addr] = m_result();
          m_phase = 0;
        end
      endcase
    end
  end

  task automatic check(string req, string what, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d exp %0d", req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check("R2", "slot_ready", slot_ready, m_phase == 1);
      check("R6", "result_valid", result_valid, m_phase == 2);
      if (m_phase == 2) check(cur_req, "result_data", result_data, m_result());
    end
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog got %0d exp 0", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [19:0] pat(int seed, int k);
    logic [19:0] v;
    for (int l = 0; l < 4; l++)
      v[l*5 +: 5] = (seed == -1) ? 5'd31 : (seed == -2) ? 5'd0 : 5'((seed*7 + k*13 + l*5 + l*k) % 32);
    return v;
  endfunction

  // called at a negedge; returns at a negedge in idle
  task automatic run_op(bit wide, int addr, bit addp, bit st, int seed, int gap, bit poke);
    start = 1; wide_mode = wide; buf_addr = 4'(addr); add_prev = addp; store_result = st;
    @(negedge clk);
    start = 0;
    for (int k = 0; k < (wide ? 4 : 1); k++) begin
      for (int g = 0; g < gap; g++) begin
        slot_valid = 0; slot_data = 20'hFFFFF;
        @(negedge clk);
      end
      slot_valid = 1; slot_data = pat(seed, k);
      if (poke && k == 1) begin
        start = 1; wide_mode = ~wide; buf_addr = ~buf_addr; add_prev = ~addp; store_result = ~st;
      end
      @(negedge clk);
      start = 0; wide_mode = wide; buf_addr = 4'(addr); add_prev = addp; store_result = st;
    end
    // valid cycle: offer a slot that must be ignored
    slot_valid = 1; slot_data = 20'hFFFFF;
    @(negedge clk);
    slot_valid = 0; slot_data = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "slot_ready in reset", slot_ready, 0);
    check("R1", "result_valid in reset", result_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", "slot_ready after reset", slot_ready, 0);

    // R7: slots offered while idle are ignored
    slot_valid = 1; slot_data = 20'h12345;
    repeat (2) @(negedge clk);
    slot_valid = 0;
    cur_req = "R7";
    run_op(0, 0, 0, 0, -2, 0, 0);

    // R1: buffer entry starts at zero
    cur_req = "R1";
    run_op(0, 9, 1, 0, -2, 0, 0);

    // R3 / R5: narrow mode, several patterns
    cur_req = "R3";
    for (int s = 1; s < 6; s++) run_op(0, 0, 0, 0, s, 0, 0);
    cur_req = "R5";
    run_op(0, 0, 0, 0, -1, 0, 0);

    // R4: wide mode with and without gaps
    cur_req = "R4";
    for (int s = 1; s < 6; s++) run_op(1, 0, 0, 0, s, s % 3, 0);
    run_op(1, 0, 0, 0, -1, 2, 0);

    // R2: start during an operation is ignored
    cur_req = "R2";
    run_op(1, 2, 0, 0, 11, 1, 1);
    run_op(0, 2, 0, 0, 12, 0, 1);

    // R9 / R8: store then read back
    cur_req = "R9";
    run_op(1, 3, 0, 1, 21, 0, 0);
    run_op(0, 3, 1, 0, -2, 0, 0);
    cur_req = "R8";
    run_op(0, 3, 1, 0, 4, 0, 0);
    run_op(0, 3, 0, 0, 4, 0, 0);
    run_op(1, 3, 1, 1, 7, 1, 0);
    run_op(0, 3, 1, 0, -2, 0, 0);

    // R10: chain until the running sum wraps
    cur_req = "R10";
    for (int i = 0; i < 480; i++) run_op(1, 5, 1, 1, -1, 0, 0);
    run_op(0, 5, 1, 0, -2, 0, 0);
    check("R10", "wrapped entry", m_buf[5], (longint'(480) * 35836) & 64'hFFFFFF);

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule